// File: doc/BRIEF.md
# Memory-to-Stream Burst Reader

This block fetches a run of data words from system memory over an AXI4 read port and hands them, in address order, to a downstream consumer as a plain valid/data stream. A controller gives it a physical byte address and a word count with a one-cycle load pulse. The block then cuts the run into incrementing read bursts, puts each on the read-address channel, and steps the address by one burst's worth of bytes after every address handshake.

Returning beats go into an internal FIFO and are forwarded from there. A burst is only requested when the FIFO has room reserved for every beat of it, so the read-data channel never needs to be stalled. Transaction IDs are always zero and responses are assumed to arrive in order and without error. The response code, ID and last-beat flag of the data channel stop inside the block.

The consumer does not use a full handshake. Every cycle with `st_valid` high carries a good word. A low `st_ready` asks the block to stop sending, and the block honours it at the next clock edge. When the last requested word has been sent, `busy` falls and `done` rises, and `done` stays high until the next accepted load.

Top module: `mem_burst_streamer`

## Requirements
- R1: Out of reset `busy`, `done`, `m_arvalid` and `st_valid` are low and `m_rready` is high.
- R2: `cfg_load` is taken only while `busy` is low. A load taken with a non-zero count raises `busy` and clears `done` in the next cycle. A `cfg_load` while busy changes neither the words sent nor their addresses.
- R3: Every read-address request carries ID 0, burst type INCR (2'b01) and a size code of log2(DATA_W/8), which is 3 for 64-bit data.
- R4: The first burst starts at the loaded address. Each later burst starts (DATA_W/8)*BURST_LEN bytes above the previous one, which is 64 bytes with the defaults.
- R5: ARLEN is BURST_LEN-1 (7 with the defaults) for every burst except the last, which is trimmed to the remaining count minus one. Exactly ceil(count/BURST_LEN) bursts are issued.
- R6: A burst is issued only when the beats already requested but not yet sent, plus the new burst's beats, fit in FIFO_DEPTH. `m_rready` stays high and the FIFO never overflows.
- R7: Stream words appear in address order, with word i equal to the memory word at start + i*(DATA_W/8). Read response codes and the last-beat flag do not affect the data or the count.
- R8: `st_valid` is high in a cycle only if `st_ready` was high at the clock edge that began that cycle.
- R9: `done` rises and `busy` falls in the same cycle that the final word is on the stream. Exactly the loaded number of words is sent, and `done` stays high until the next accepted load.
- R10: A load with a count of zero raises `done` in the next cycle, leaves `busy` low and issues no burst. No read-address request is valid while `busy` is low.
- R11: Once `m_arvalid` is high it stays high, with address and length unchanged, until `m_arready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle load strobe for a new job |
| cfg_addr | input | ADDR_W | Physical byte address of the first word |
| cfg_words | input | CNT_W | Number of words to fetch |
| busy | output | 1 | Job in progress |
| done | output | 1 | All words of the last job sent (sticky) |
| m_arid | output | ID_W | Read-address ID, tied to zero |
| m_araddr | output | ADDR_W | Burst start address |
| m_arlen | output | 8 | Beats in burst minus one |
| m_arsize | output | 3 | Bytes-per-beat code |
| m_arburst | output | 2 | Burst type (INCR) |
| m_arvalid | output | 1 | Read-address request valid |
| m_arready | input | 1 | Read-address accepted |
| m_rid | input | ID_W | Read-data ID (unused) |
| m_rdata | input | DATA_W | Read data beat |
| m_rresp | input | 2 | Read response (unused) |
| m_rlast | input | 1 | Last beat of burst (unused) |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data accepted, held high |
| st_data | output | DATA_W | Stream word |
| st_valid | output | 1 | Stream word present |
| st_ready | input | 1 | Low requests the stream to stop |

## Verification
Two events can land in the same clock edge: a stream pop that releases FIFO credit, and the credit test that issues the next burst. A read beat can also be pushed into the FIFO at the same edge that another word is popped out. The bench sets these up by letting `st_ready` and the memory model's beat gaps and address acceptance vary from cycle to cycle during a long job, and by holding the stream stopped while the memory keeps offering data. At every address handshake the bench checks the requested-minus-sent beat count against FIFO_DEPTH, and it checks every stream word against its address-derived value. A lost or doubled beat at a coinciding push and pop therefore shows up as a data or count mismatch.

// File: rtl/msr_pkg.sv
package msr_pkg;
   localparam logic [1:0] BURST_INCR = 2'b01;

   function automatic logic [2:0] beat_size_code(input int data_w);
      return 3'($clog2(data_w / 8));
   endfunction
endpackage

// File: rtl/msr_fifo.sv
module msr_fifo #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [LVL_W-1:0]  level
);
   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("msr_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic [LVL_W-1:0]  count;

   always_ff @(posedge clk) begin
      if (push) store[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         count <= count + LVL_W'(push) - LVL_W'(pop);
      end
   end

   assign head  = store[rd_ptr];
   assign level = count;
endmodule

// File: rtl/msr_ar_issuer.sv
module msr_ar_issuer #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 64,
   parameter int CNT_W     = 16,
   parameter int BURST_LEN = 8,
   parameter int LVL_W     = 5,
   localparam int LEN_W    = $clog2(BURST_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  start_words,
   input  logic [LVL_W-1:0]  free_slots,
   input  logic              arready,
   output logic [ADDR_W-1:0] araddr,
   output logic [7:0]        arlen,
   output logic              arvalid,
   output logic              issue,
   output logic [LEN_W-1:0]  issue_beats
);
   localparam int STEP_BYTES = (DATA_W / 8) * BURST_LEN;

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [7:0]        len_q;
   logic              valid_q;
   logic [LEN_W-1:0]  next_beats;
   logic              room_ok;

   always_comb begin
      if (left_q >= CNT_W'(BURST_LEN)) next_beats = LEN_W'(BURST_LEN);
      else                             next_beats = LEN_W'(left_q);
      room_ok = 32'(free_slots) >= 32'(next_beats);
      issue   = !valid_q && (left_q != '0) && room_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         left_q  <= '0;
         len_q   <= '0;
         valid_q <= 1'b0;
      end else if (start) begin
         addr_q  <= start_addr;
         left_q  <= start_words;
         valid_q <= 1'b0;
      end else if (issue) begin
         valid_q <= 1'b1;
         len_q   <= 8'(next_beats) - 8'd1;
         left_q  <= left_q - CNT_W'(next_beats);
      end else if (valid_q && arready) begin
         valid_q <= 1'b0;
         addr_q  <= addr_q + ADDR_W'(STEP_BYTES);
      end
   end

   assign araddr      = addr_q;
   assign arlen       = len_q;
   assign arvalid     = valid_q;
   assign issue_beats = next_beats;
endmodule

// File: rtl/msr_credit.sv
module msr_credit #(
   parameter int DEPTH = 16,
   parameter int LEN_W = 4,
   parameter int LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [LEN_W-1:0] issue_beats,
   input  logic             pop,
   output logic [LVL_W-1:0] free_slots
);
   logic [LVL_W-1:0] reserved_q;
   logic [LVL_W-1:0] add_beats;

   assign add_beats = issue ? LVL_W'(issue_beats) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) reserved_q <= '0;
      else        reserved_q <= reserved_q + add_beats - LVL_W'(pop);
   end

   assign free_slots = LVL_W'(DEPTH) - reserved_q;
endmodule

// File: rtl/msr_stream_out.sv
module msr_stream_out #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 16,
   parameter int LVL_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  start_words,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic [DATA_W-1:0] head,
   input  logic              st_ready,
   output logic              pop,
   output logic [DATA_W-1:0] st_data,
   output logic              st_valid,
   output logic              busy,
   output logic              done
);
   logic [CNT_W-1:0]  total_q;
   logic [CNT_W-1:0]  sent_q;
   logic [DATA_W-1:0] data_q;
   logic              valid_q;
   logic              busy_q;
   logic              done_q;

   assign pop = busy_q && (fifo_level != '0) && st_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         total_q <= '0;
         sent_q  <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else if (start) begin
         total_q <= start_words;
         sent_q  <= '0;
         valid_q <= 1'b0;
         busy_q  <= (start_words != '0);
         done_q  <= (start_words == '0);
      end else begin
         valid_q <= pop;
         if (pop) begin
            data_q <= head;
            sent_q <= sent_q + CNT_W'(1);
            if (sent_q == total_q - CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign st_data  = data_q;
   assign st_valid = valid_q;
   assign busy     = busy_q;
   assign done     = done_q;
endmodule

// File: rtl/mem_burst_streamer.sv
module mem_burst_streamer #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int ID_W       = 4,
   parameter int CNT_W      = 16,
   parameter int BURST_LEN  = 8,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_words,
   output logic              busy,
   output logic              done,
   output logic [ID_W-1:0]   m_arid,
   output logic [ADDR_W-1:0] m_araddr,
   output logic [7:0]        m_arlen,
   output logic [2:0]        m_arsize,
   output logic [1:0]        m_arburst,
   output logic              m_arvalid,
   input  logic              m_arready,
   input  logic [ID_W-1:0]   m_rid,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic [1:0]        m_rresp,
   input  logic              m_rlast,
   input  logic              m_rvalid,
   output logic              m_rready,
   output logic [DATA_W-1:0] st_data,
   output logic              st_valid,
   input  logic              st_ready
);
   localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
   localparam int LEN_W = $clog2(BURST_LEN + 1);
   localparam logic [2:0] SIZE_CODE = msr_pkg::beat_size_code(DATA_W);

   if (DATA_W < 8 || DATA_W > 1024 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("mem_burst_streamer: DATA_W must be a power of two from 8 to 1024");
   end
   if (BURST_LEN < 1 || BURST_LEN > 256) begin : g_bad_len
      $error("mem_burst_streamer: BURST_LEN must be 1 to 256");
   end
   if (BURST_LEN > FIFO_DEPTH) begin : g_bad_room
      $error("mem_burst_streamer: FIFO_DEPTH must hold a whole burst");
   end
   if (CNT_W < LEN_W) begin : g_bad_cnt
      $error("mem_burst_streamer: CNT_W too narrow for BURST_LEN");
   end

   logic              accept;
   logic              pop;
   logic              issue;
   logic [LEN_W-1:0]  issue_beats;
   logic [LVL_W-1:0]  free_slots;
   logic [LVL_W-1:0]  fifo_level;
   logic [DATA_W-1:0] fifo_head;
   logic              unused_rside;

   assign accept       = cfg_load && !busy;
   assign unused_rside = ^{m_rid, m_rresp, m_rlast};

   msr_ar_issuer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .BURST_LEN(BURST_LEN), .LVL_W(LVL_W)
   ) u_issuer (
      .clk(clk), .rst_n(rst_n), .start(accept), .start_addr(cfg_addr),
      .start_words(cfg_words), .free_slots(free_slots), .arready(m_arready),
      .araddr(m_araddr), .arlen(m_arlen), .arvalid(m_arvalid),
      .issue(issue), .issue_beats(issue_beats)
   );

   msr_credit #(.DEPTH(FIFO_DEPTH), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_credit (
      .clk(clk), .rst_n(rst_n), .issue(issue), .issue_beats(issue_beats),
      .pop(pop), .free_slots(free_slots)
   );

   msr_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(m_rvalid), .push_data(m_rdata),
      .pop(pop), .head(fifo_head), .level(fifo_level)
   );

   msr_stream_out #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_out (
      .clk(clk), .rst_n(rst_n), .start(accept), .start_words(cfg_words),
      .fifo_level(fifo_level), .head(fifo_head), .st_ready(st_ready),
      .pop(pop), .st_data(st_data), .st_valid(st_valid),
      .busy(busy), .done(done)
   );

   assign m_arid    = '0;
   assign m_arsize  = SIZE_CODE;
   assign m_arburst = msr_pkg::BURST_INCR;
   assign m_rready  = 1'b1;
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int BURST_LEN  = 8,
   parameter int FIFO_DEPTH = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_load,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] m_araddr,
   input logic [7:0]        m_arlen,
   input logic              m_arvalid,
   input logic              m_arready,
   input logic              m_rvalid,
   input logic              m_rready,
   input logic              st_valid,
   input logic              st_ready
);
   localparam int STEP_BYTES = (DATA_W / 8) * BURST_LEN;

   logic              ar_hs;
   logic              have_prev;
   logic [ADDR_W-1:0] prev_addr;
   logic [ADDR_W-1:0] start_q;
   int                level_seen;

   assign ar_hs = m_arvalid && m_arready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_prev  <= 1'b0;
         prev_addr  <= '0;
         start_q    <= '0;
         level_seen <= 0;
      end else begin
         if (cfg_load && !busy) begin
            start_q   <= cfg_addr;
            have_prev <= 1'b0;
         end else if (ar_hs) begin
            have_prev <= 1'b1;
            prev_addr <= m_araddr;
         end
         level_seen <= level_seen + int'(m_rvalid && m_rready) - int'(st_valid);
      end
   end

   a_r4_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_hs && !have_prev) |-> (m_araddr == start_q));
   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_hs && have_prev) |-> (m_araddr == prev_addr + ADDR_W'(STEP_BYTES)));
   a_r11_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr) && $stable(m_arlen)));
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      level_seen <= FIFO_DEPTH);
   a_r8_stop_honoured: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> $past(st_ready));
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r10_no_idle_request: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid |-> busy);
endmodule

bind mem_burst_streamer msr_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
   .busy(busy), .done(done), .m_araddr(m_araddr), .m_arlen(m_arlen),
   .m_arvalid(m_arvalid), .m_arready(m_arready), .m_rvalid(m_rvalid),
   .m_rready(m_rready), .st_valid(st_valid), .st_ready(st_ready)
);

// File: tb/tb_mem_burst_streamer.sv
module tb_mem_burst_streamer;
   localparam int ADDR_W = 32, DATA_W = 64, ID_W = 4, CNT_W = 16;
   localparam int BLEN = 8, DEPTH = 16;

   logic clk = 1'b0;
   logic rst_n;
   logic cfg_load;
   logic [ADDR_W-1:0] cfg_addr;
   logic [CNT_W-1:0] cfg_words;
   logic busy, done;
   logic [ID_W-1:0] m_arid;
   logic [ADDR_W-1:0] m_araddr;
   logic [7:0] m_arlen;
   logic [2:0] m_arsize;
   logic [1:0] m_arburst;
   logic m_arvalid, m_arready;
   logic [ID_W-1:0] m_rid;
   logic [DATA_W-1:0] m_rdata;
   logic [1:0] m_rresp;
   logic m_rlast, m_rvalid, m_rready;
   logic [DATA_W-1:0] st_data;
   logic st_valid, st_ready;

   mem_burst_streamer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .CNT_W(CNT_W),
      .BURST_LEN(BLEN), .FIFO_DEPTH(DEPTH)
   ) dut (.*);

   always #5 clk = ~clk;

   int nchecks = 0, nerr = 0;
   int exp_words = 0, stream_idx = 0;
   int ar_left = 0, ar_beats = 0, ar_count = 0;
   int ready_mode = 0;
   bit slave_rand = 0;
   bit prev_ready = 1'b1;
   logic [31:0] exp_base = '0, exp_ar_addr = '0;
   logic [31:0] q_addr [64];
   int q_len [64];
   int q_wr = 0, q_rd = 0, beat = 0;

   function automatic logic [63:0] mem_word(input logic [31:0] a);
      return {~a, a};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   // stream consumer and per-word checks
   initial begin
      st_ready = 1'b1;
      forever begin
         @(negedge clk);
         if (st_valid) begin
            check(prev_ready, "R8", "word after stop request", 64'(prev_ready), 64'd1);
            check(st_data == mem_word(exp_base + 32'(stream_idx * 8)), "R7", "stream word",
                  st_data, mem_word(exp_base + 32'(stream_idx * 8)));
            stream_idx++;
            if (stream_idx == exp_words)
               check(done && !busy, "R9", "done/busy on final word", {62'd0, done, busy}, 64'h2);
            else
               check(!done && busy, "R9", "done/busy mid job", {62'd0, done, busy}, 64'h1);
         end
         case (ready_mode)
            0:       st_ready = 1'b1;
            1:       st_ready = ($urandom_range(0, 3) != 0);
            default: st_ready = 1'b0;
         endcase
         prev_ready = st_ready;
      end
   end

   // memory model: data channel first, then address channel
   initial begin
      m_arready = 1'b0; m_rvalid = 1'b0; m_rdata = '0; m_rresp = '0;
      m_rlast = 1'b0; m_rid = '0;
      forever begin
         @(negedge clk);
         if (q_rd != q_wr && (!slave_rand || $urandom_range(0, 3) != 0)) begin
            m_rvalid = 1'b1;
            m_rdata  = mem_word(q_addr[q_rd % 64] + 32'(beat * 8));
            m_rresp  = 2'(beat);
            m_rlast  = (beat == q_len[q_rd % 64] - 1);
            beat++;
            if (m_rlast) begin beat = 0; q_rd++; end
         end else begin
            m_rvalid = 1'b0;
            m_rlast  = 1'b0;
         end
         if (m_arready) m_arready = 1'b0;
         else if (m_arvalid && (!slave_rand || $urandom_range(0, 1) == 1)) begin
            int elen;
            elen = (ar_left >= BLEN) ? BLEN : ar_left;
            check(ar_left > 0, "R5", "burst beyond count", 64'(ar_left), 64'd1);
            check(m_araddr == exp_ar_addr, "R4", "burst address", 64'(m_araddr), 64'(exp_ar_addr));
            check(m_arlen == 8'(elen - 1), "R5", "burst length", 64'(m_arlen), 64'(elen - 1));
            check(m_arid == '0 && m_arsize == 3'd3 && m_arburst == 2'b01, "R3", "id/size/type",
                  {52'd0, m_arid, 3'd0, m_arsize, 2'd0, m_arburst}, 64'h31);
            check(ar_beats + int'(m_arlen) + 1 - stream_idx <= DEPTH, "R6", "credit bound",
                  64'(ar_beats + int'(m_arlen) + 1 - stream_idx), 64'(DEPTH));
            q_addr[q_wr % 64] = m_araddr;
            q_len[q_wr % 64]  = int'(m_arlen) + 1;
            q_wr++;
            exp_ar_addr = exp_ar_addr + 32'd64;
            ar_left  = ar_left - elen;
            ar_beats = ar_beats + int'(m_arlen) + 1;
            ar_count++;
            m_arready = 1'b1;
         end
      end
   end

   task automatic start_job(input logic [31:0] base, input int words);
      exp_base = base; exp_words = words; stream_idx = 0;
      exp_ar_addr = base; ar_left = words; ar_beats = 0; ar_count = 0;
      @(negedge clk);
      cfg_load = 1'b1; cfg_addr = base; cfg_words = 16'(words);
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic wait_done(input string req, input int limit);
      int n = 0;
      while (!done && n < limit) begin @(negedge clk); n++; end
      check(done, req, "job completion", 64'(done), 64'd1);
      repeat (20) @(negedge clk);
      check(stream_idx == exp_words, req, "words sent", 64'(stream_idx), 64'(exp_words));
      check(ar_left == 0, req, "words left unrequested", 64'(ar_left), 64'd0);
   endtask

   task automatic t_reset();
      check(!busy && !done, "R1", "busy/done after reset", {62'd0, busy, done}, 64'd0);
      check(!m_arvalid && !st_valid, "R1", "arvalid/st_valid after reset",
            {62'd0, m_arvalid, st_valid}, 64'd0);
      check(m_rready, "R1", "rready after reset", 64'(m_rready), 64'd1);
   endtask

   task automatic t_full_bursts();
      ready_mode = 0; slave_rand = 0;
      start_job(32'h8000_0000, 32);
      check(busy && !done, "R2", "busy after load", {62'd0, busy, done}, 64'h2);
      wait_done("R9", 2000);
      check(ar_count == 4, "R4", "full burst count", 64'(ar_count), 64'd4);
   endtask

   task automatic t_trimmed();
      ready_mode = 0; slave_rand = 0;
      start_job(32'h0001_0040, 19);
      wait_done("R5", 2000);
      check(ar_count == 3, "R5", "trimmed burst count", 64'(ar_count), 64'd3);
   endtask

   task automatic t_backpressure();
      ready_mode = 1; slave_rand = 1;
      start_job(32'h2000_0000, 100);
      wait_done("R7", 20000);
   endtask

   task automatic t_stall();
      ready_mode = 2; slave_rand = 0;
      start_job(32'h3000_0000, 64);
      repeat (60) @(negedge clk);
      check(ar_beats == DEPTH, "R6", "beats requested while stopped", 64'(ar_beats), 64'(DEPTH));
      check(stream_idx == 0, "R8", "words sent while stopped", 64'(stream_idx), 64'd0);
      ready_mode = 0;
      wait_done("R6", 4000);
   endtask

   task automatic t_ignore_load();
      ready_mode = 1; slave_rand = 0;
      start_job(32'h4000_0000, 40);
      repeat (5) @(negedge clk);
      cfg_load = 1'b1; cfg_addr = 32'h5555_0000; cfg_words = 16'd3;
      @(negedge clk);
      cfg_load = 1'b0;
      check(busy && !done, "R2", "state after ignored load", {62'd0, busy, done}, 64'h2);
      wait_done("R2", 4000);
   endtask

   task automatic t_zero();
      ready_mode = 0; slave_rand = 0;
      start_job(32'h6000_0000, 0);
      check(done && !busy, "R10", "zero-count load", {62'd0, done, busy}, 64'h2);
      repeat (20) @(negedge clk);
      check(ar_count == 0, "R10", "bursts for zero count", 64'(ar_count), 64'd0);
      check(done, "R9", "done held while idle", 64'(done), 64'd1);
   endtask

   task automatic t_restart();
      ready_mode = 0; slave_rand = 1;
      start_job(32'h7000_0000, 9);
      check(!done && busy, "R9", "done cleared by new load", {62'd0, done, busy}, 64'h1);
      wait_done("R9", 2000);
      check(ar_count == 2, "R5", "bursts for nine words", 64'(ar_count), 64'd2);
   endtask

   initial begin
      rst_n = 1'b0; cfg_load = 1'b0; cfg_addr = '0; cfg_words = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_bursts();
      t_trimmed();
      t_backpressure();
      t_stall();
      t_ignore_load();
      t_zero();
      t_restart();
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchecks++; nerr++;
      $display("FAIL R9 watchdog: got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   end
endmodule